// File: doc/BRIEF.md
# UART FIFO Register Block

This block is the software-facing half of a simple serial port. It sits on a word-wide register bus and holds two byte queues. Bytes written by software enter the transmit queue and leave it on a valid/ready byte stream toward a serial shifter. Bytes arriving from the line side on a valid-only stream enter the receive queue, and software drains them by reading a data register. The baud divisor is only stored and exported on a port for the bit-timing logic elsewhere.

Each queue has a programmable watermark that sets a read-only pending bit. A single level interrupt is formed from two enable bits and from whether the receive queue is empty. Only aligned 32-bit accesses are carried out. Any other access is refused with a one-cycle error pulse and has no effect.

Register offsets, as byte addresses: 0x00 interrupt enable, 0x04 interrupt pending, 0x08 transmit data, 0x0C receive data, 0x10 transmit config, 0x14 receive config, 0x18 baud divisor. All other offsets are unmapped.

Top module: `uart_fifo_regs`

## Requirements
- R1: An access is carried out only when `bus_size` is 2 (four bytes) and `bus_addr[1:0]` is 0. Any other access has no effect on state and gives `bus_err` high for one cycle, in the cycle after the request, with `bus_rvalid` low.
- R2: An accepted read of offset 0x0C while the receive queue holds data returns the oldest byte in bits 7:0 with all other bits zero, and removes that byte from the queue.
- R3: An accepted read of offset 0x0C while the receive queue is empty returns 0x80000000 and changes no state.
- R4: An accepted write to offset 0x08 appends `bus_wdata[7:0]` to the transmit queue. `tx_valid` is high while the queue is not empty, and `tx_data` shows its oldest byte. A byte leaves the queue on a clock edge where `tx_valid` and `tx_ready` are both high, and bytes leave in write order.
- R5: A write to offset 0x08 while the transmit queue holds 8 bytes is discarded.
- R6: A read of offset 0x08 returns bit 31 set when the transmit queue holds 8 bytes, and returns zero once at least one byte has drained. All other bits read zero.
- R7: A byte presented on `rx_valid` while the receive queue holds 8 bytes is dropped.
- R8: Offset 0x04 is read-only. Bit 1 is high when the receive occupancy is strictly greater than bits 18:16 of the receive config. Bit 0 is high when the transmit occupancy is strictly less than bits 18:16 of the transmit config.
- R9: `irq` is high exactly when enable bit 0 is set, or when enable bit 1 is set and the receive queue is not empty. A write to the enable register is seen on `irq` in the cycle after the request.
- R10: After reset the enable, config and divisor registers read zero, both queues are empty, `tx_valid` and `irq` are low, and `baud_div` is zero.
- R11: The transmit config, receive config and divisor registers read back the full 32-bit value last written. The enable register keeps bits 1:0 and reads zero elsewhere. `baud_div` always equals the divisor register.
- R12: An accepted read of an unmapped offset returns zero with `bus_rvalid` high. Writes to unmapped offsets and to offset 0x04 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 5 | Byte offset of the access |
| bus_size | input | 2 | Log2 of the access size in bytes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_rvalid | output | 1 | Pulse marking bus_rdata for an accepted read |
| bus_err | output | 1 | Pulse marking a refused access |
| tx_data | output | 8 | Oldest transmit byte |
| tx_valid | output | 1 | Transmit queue not empty |
| tx_ready | input | 1 | Line side takes tx_data |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | rx_data holds a new byte this cycle |
| irq | output | 1 | Level interrupt |
| baud_div | output | 32 | Stored baud divisor |

## Verification
The assertions assume that a request lasts one cycle and that `bus_addr`, `bus_size` and `bus_we` are meaningful only while `bus_req` is high. They also assume that the line side holds `tx_ready` as a plain input that does not depend on `tx_data`. The bench drives every input on the falling edge, raises `bus_req` for exactly one cycle per task call, and pulses `tx_ready` and `rx_valid` separately from bus traffic. As a result, no push and pop of the same queue coincide in a way that would make the expected occupancy ambiguous.

// File: rtl/uart_fifo_regs_pkg.sv
package uart_fifo_regs_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned OFFS_W   = 5;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned WM_LSB   = 16;
  localparam int unsigned WM_W     = 3;
  localparam int unsigned FLAG_BIT = 31;
  localparam logic [1:0]  SIZE_WORD = 2'd2;

  localparam logic [OFFS_W-1:0] OFF_INTEN   = 5'h00;
  localparam logic [OFFS_W-1:0] OFF_INTPEND = 5'h04;
  localparam logic [OFFS_W-1:0] OFF_TXDATA  = 5'h08;
  localparam logic [OFFS_W-1:0] OFF_RXDATA  = 5'h0C;
  localparam logic [OFFS_W-1:0] OFF_TXCFG   = 5'h10;
  localparam logic [OFFS_W-1:0] OFF_RXCFG   = 5'h14;
  localparam logic [OFFS_W-1:0] OFF_BAUD    = 5'h18;

  typedef enum logic [2:0] {
    SEL_INTEN,
    SEL_INTPEND,
    SEL_TXDATA,
    SEL_RXDATA,
    SEL_TXCFG,
    SEL_RXCFG,
    SEL_BAUD,
    SEL_NONE
  } reg_sel_e;
endpackage

// File: rtl/uart_byte_fifo.sv
module uart_byte_fifo #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         push,
  input  logic [WIDTH-1:0]             push_data,
  input  logic                         pop,
  output logic [WIDTH-1:0]             head,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         full,
  output logic                         empty
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH+1);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH-1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] count_q;
  logic             push_ok, pop_ok;

  assign full    = (count_q == FULL_CNT);
  assign empty   = (count_q == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign count   = count_q;
  assign head    = mem_q[rd_ptr_q];

  // storage without reset so it maps onto distributed RAM
  always_ff @(posedge clk) begin
    if (push_ok) mem_q[wr_ptr_q] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (push_ok) wr_ptr_q <= (wr_ptr_q == LAST_PTR) ? '0 : wr_ptr_q + 1'b1;
      if (pop_ok)  rd_ptr_q <= (rd_ptr_q == LAST_PTR) ? '0 : rd_ptr_q + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  // R5 R7: a push into a full queue without a pop leaves it full
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop) |=> (count == FULL_CNT));

  // R3: a pop from an empty queue without a push leaves it empty
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    (pop && empty && !push) |=> empty);
endmodule

// File: rtl/uart_bus_decode.sv
module uart_bus_decode
  import uart_fifo_regs_pkg::*;
(
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [OFFS_W-1:0] bus_addr,
  input  logic [1:0]        bus_size,
  output logic              acc_ok,
  output logic              acc_bad,
  output logic              wr_en,
  output logic              rd_en,
  output reg_sel_e          sel
);
  logic shape_ok;

  assign shape_ok = (bus_size == SIZE_WORD) && (bus_addr[1:0] == 2'b00);
  assign acc_ok   = bus_req && shape_ok;
  assign acc_bad  = bus_req && !shape_ok;
  assign wr_en    = acc_ok && bus_we;
  assign rd_en    = acc_ok && !bus_we;

  always_comb begin
    unique case (bus_addr)
      OFF_INTEN:   sel = SEL_INTEN;
      OFF_INTPEND: sel = SEL_INTPEND;
      OFF_TXDATA:  sel = SEL_TXDATA;
      OFF_RXDATA:  sel = SEL_RXDATA;
      OFF_TXCFG:   sel = SEL_TXCFG;
      OFF_RXCFG:   sel = SEL_RXCFG;
      OFF_BAUD:    sel = SEL_BAUD;
      default:     sel = SEL_NONE;
    endcase
  end
endmodule

// File: rtl/uart_irq_logic.sv
module uart_irq_logic
  import uart_fifo_regs_pkg::*;
#(
  parameter int unsigned CNT_W = 4
) (
  input  logic [1:0]       ien,
  input  logic [CNT_W-1:0] tx_count,
  input  logic [CNT_W-1:0] rx_count,
  input  logic [WM_W-1:0]  tx_mark,
  input  logic [WM_W-1:0]  rx_mark,
  input  logic             rx_empty,
  output logic [1:0]       pend,
  output logic             irq
);
  localparam int unsigned CMP_W = (CNT_W > WM_W) ? CNT_W : WM_W;

  logic [CMP_W-1:0] tx_c, rx_c, tx_m, rx_m;

  assign tx_c = CMP_W'(tx_count);
  assign rx_c = CMP_W'(rx_count);
  assign tx_m = CMP_W'(tx_mark);
  assign rx_m = CMP_W'(rx_mark);

  assign pend[0] = (tx_c < tx_m);
  assign pend[1] = (rx_c > rx_m);

  // level output formed from flops through a single gate level
  assign irq = ien[0] || (ien[1] && !rx_empty);
endmodule

// File: rtl/uart_fifo_regs.sv
module uart_fifo_regs
  import uart_fifo_regs_pkg::*;
#(
  parameter int unsigned TX_DEPTH = 8,
  parameter int unsigned RX_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [4:0]        bus_addr,
  input  logic [1:0]        bus_size,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid,
  output logic              bus_err,
  output logic [7:0]        tx_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  input  logic [7:0]        rx_data,
  input  logic              rx_valid,
  output logic              irq,
  output logic [31:0]       baud_div
);
  localparam int unsigned TX_CNT_W = $clog2(TX_DEPTH+1);
  localparam int unsigned RX_CNT_W = $clog2(RX_DEPTH+1);
  localparam int unsigned CNT_W    = (TX_CNT_W > RX_CNT_W) ? TX_CNT_W : RX_CNT_W;
  localparam logic [WORD_W-1:0] EMPTY_WORD = WORD_W'(1) << FLAG_BIT;

  logic              acc_ok, acc_bad, wr_en, rd_en;
  reg_sel_e          sel;
  logic [1:0]        ien_q;
  logic [WORD_W-1:0] txcfg_q, rxcfg_q, baud_q;
  logic [WORD_W-1:0] rdata_d, rdata_q;
  logic              rvalid_q, err_q;

  logic [BYTE_W-1:0]   tx_head, rx_head;
  logic [TX_CNT_W-1:0] tx_count;
  logic [RX_CNT_W-1:0] rx_count;
  logic                tx_full, tx_empty, rx_full, rx_empty;
  logic                tx_push, tx_pop, rx_pop;
  logic [1:0]          pend;

  uart_bus_decode u_decode (
    .bus_req  (bus_req),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .bus_size (bus_size),
    .acc_ok   (acc_ok),
    .acc_bad  (acc_bad),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .sel      (sel)
  );

  assign tx_push = wr_en && (sel == SEL_TXDATA);
  assign tx_pop  = tx_valid && tx_ready;
  assign rx_pop  = rd_en && (sel == SEL_RXDATA);

  uart_byte_fifo #(.WIDTH(BYTE_W), .DEPTH(TX_DEPTH)) u_tx_fifo (
    .clk       (clk),
    .rst       (rst),
    .push      (tx_push),
    .push_data (bus_wdata[BYTE_W-1:0]),
    .pop       (tx_pop),
    .head      (tx_head),
    .count     (tx_count),
    .full      (tx_full),
    .empty     (tx_empty)
  );

  uart_byte_fifo #(.WIDTH(BYTE_W), .DEPTH(RX_DEPTH)) u_rx_fifo (
    .clk       (clk),
    .rst       (rst),
    .push      (rx_valid),
    .push_data (rx_data),
    .pop       (rx_pop),
    .head      (rx_head),
    .count     (rx_count),
    .full      (rx_full),
    .empty     (rx_empty)
  );

  uart_irq_logic #(.CNT_W(CNT_W)) u_irq (
    .ien      (ien_q),
    .tx_count (CNT_W'(tx_count)),
    .rx_count (CNT_W'(rx_count)),
    .tx_mark  (txcfg_q[WM_LSB +: WM_W]),
    .rx_mark  (rxcfg_q[WM_LSB +: WM_W]),
    .rx_empty (rx_empty),
    .pend     (pend),
    .irq      (irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ien_q   <= '0;
      txcfg_q <= '0;
      rxcfg_q <= '0;
      baud_q  <= '0;
    end else if (wr_en) begin
      case (sel)
        SEL_INTEN: ien_q   <= bus_wdata[1:0];
        SEL_TXCFG: txcfg_q <= bus_wdata;
        SEL_RXCFG: rxcfg_q <= bus_wdata;
        SEL_BAUD:  baud_q  <= bus_wdata;
        default:   ;
      endcase
    end
  end

  always_comb begin
    case (sel)
      SEL_INTEN:   rdata_d = WORD_W'(ien_q);
      SEL_INTPEND: rdata_d = WORD_W'(pend);
      SEL_TXDATA:  rdata_d = tx_full ? EMPTY_WORD : '0;
      SEL_RXDATA:  rdata_d = rx_empty ? EMPTY_WORD : WORD_W'(rx_head);
      SEL_TXCFG:   rdata_d = txcfg_q;
      SEL_RXCFG:   rdata_d = rxcfg_q;
      SEL_BAUD:    rdata_d = baud_q;
      default:     rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      rdata_q  <= rd_en ? rdata_d : '0;
      rvalid_q <= rd_en;
      err_q    <= acc_bad;
    end
  end

  assign bus_rdata  = rdata_q;
  assign bus_rvalid = rvalid_q;
  assign bus_err    = err_q;
  assign tx_data    = tx_head;
  assign tx_valid   = !tx_empty;
  assign baud_div   = baud_q;

  // R1
  bad_size_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_size != SIZE_WORD) |=> (bus_err && !bus_rvalid));

  // R3
  rx_empty_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && sel == SEL_RXDATA && rx_empty) |=> (bus_rdata == EMPTY_WORD));

  // R6
  tx_full_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && sel == SEL_TXDATA && tx_full) |=> bus_rdata[FLAG_BIT]);

  // R4
  tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  // R9
  ien_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && sel == SEL_INTEN && bus_wdata[0]) |=> irq);

  // R10
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!irq && !tx_valid && baud_div == '0));
endmodule

// File: tb/uart_fifo_regs_bench.sv
module uart_fifo_regs_bench;
  localparam int CLK_PERIOD = 10;

  localparam logic [4:0] A_IEN  = 5'h00;
  localparam logic [4:0] A_IPND = 5'h04;
  localparam logic [4:0] A_TXD  = 5'h08;
  localparam logic [4:0] A_RXD  = 5'h0C;
  localparam logic [4:0] A_TXC  = 5'h10;
  localparam logic [4:0] A_RXC  = 5'h14;
  localparam logic [4:0] A_BAUD = 5'h18;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_req = 1'b0, bus_we = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [1:0]  bus_size = 2'd2;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid, bus_err;
  logic [7:0]  tx_data;
  logic        tx_valid;
  logic        tx_ready = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_valid = 1'b0;
  logic        irq;
  logic [31:0] baud_div;

  int checks = 0;
  int fails  = 0;
  logic [31:0] got_data;
  logic        got_rvalid, got_err;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_fifo_regs u_uart_fifo_regs (
    .clk(clk), .rst(rst),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .bus_err(bus_err),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid),
    .irq(irq), .baud_div(baud_div)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [4:0] addr,
                        input logic [1:0] size, input logic [31:0] wdata);
    @(negedge clk);
    bus_req = 1'b1; bus_we = we; bus_addr = addr; bus_size = size; bus_wdata = wdata;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
    got_data = bus_rdata; got_rvalid = bus_rvalid; got_err = bus_err;
  endtask

  task automatic wr(input logic [4:0] addr, input logic [31:0] v);
    access(1'b1, addr, 2'd2, v);
  endtask

  task automatic rd_check(input string req, input logic [4:0] addr, input logic [31:0] exp);
    access(1'b0, addr, 2'd2, '0);
    check(req, got_data, exp);
  endtask

  task automatic rx_push(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic tx_take(input string req, input logic [7:0] exp);
    @(negedge clk);
    check(req, {31'b0, tx_valid}, 32'd1);
    check(req, {24'b0, tx_data}, {24'b0, exp});
    tx_ready = 1'b1;
    @(negedge clk);
    tx_ready = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R10 irq", {31'b0, irq}, 0);
    check("R10 tx_valid", {31'b0, tx_valid}, 0);
    check("R10 baud_div", baud_div, 0);
    rd_check("R10 ien", A_IEN, 0);
    rd_check("R10 txcfg", A_TXC, 0);
    rd_check("R10 rxcfg", A_RXC, 0);
    rd_check("R10 baud", A_BAUD, 0);
    rd_check("R10 pend", A_IPND, 0);
    rd_check("R10 txdata", A_TXD, 0);
    rd_check("R3 rx empty after reset", A_RXD, 32'h8000_0000);
    check("R12 rvalid on read", {31'b0, got_rvalid}, 1);
  endtask

  task automatic t_regs;
    wr(A_BAUD, 32'h1234_5678);
    rd_check("R11 baud", A_BAUD, 32'h1234_5678);
    check("R11 baud_div port", baud_div, 32'h1234_5678);
    wr(A_TXC, 32'hA5A5_0001);
    rd_check("R11 txcfg", A_TXC, 32'hA5A5_0001);
    wr(A_RXC, 32'h0F0F_F0F0);
    rd_check("R11 rxcfg", A_RXC, 32'h0F0F_F0F0);
    wr(A_IEN, 32'hFFFF_FFFE);
    rd_check("R11 ien bits", A_IEN, 32'h2);
    wr(A_IEN, 0);
    wr(A_TXC, 0);
    wr(A_RXC, 0);
  endtask

  task automatic t_unmapped;
    wr(5'h1C, 32'hDEAD_BEEF);
    rd_check("R12 unmapped reads zero", 5'h1C, 0);
    check("R12 unmapped rvalid", {31'b0, got_rvalid}, 1);
    wr(A_IPND, 32'h3);
    rd_check("R12 pend write ignored", A_IPND, 0);
    rd_check("R12 baud untouched", A_BAUD, 32'h1234_5678);
  endtask

  task automatic t_access;
    access(1'b1, A_BAUD, 2'd0, 32'h0000_0011);
    check("R1 byte write err", {31'b0, got_err}, 1);
    access(1'b1, 5'h19, 2'd2, 32'h0000_0022);
    check("R1 misaligned err", {31'b0, got_err}, 1);
    access(1'b0, A_BAUD, 2'd1, 0);
    check("R1 half read err", {31'b0, got_err}, 1);
    check("R1 half read no rvalid", {31'b0, got_rvalid}, 0);
    rd_check("R1 baud unchanged", A_BAUD, 32'h1234_5678);
    check("R1 good access no err", {31'b0, got_err}, 0);
    access(1'b1, A_TXD, 2'd0, 32'h55);
    @(negedge clk);
    check("R1 refused tx write", {31'b0, tx_valid}, 0);
  endtask

  task automatic t_rx;
    rx_push(8'hA1); rx_push(8'hB2); rx_push(8'hC3);
    rd_check("R2 rx first", A_RXD, 32'hA1);
    rd_check("R2 rx second", A_RXD, 32'hB2);
    rd_check("R2 rx third", A_RXD, 32'hC3);
    rd_check("R3 rx drained", A_RXD, 32'h8000_0000);
    rd_check("R3 still empty", A_RXD, 32'h8000_0000);
  endtask

  task automatic t_rx_overflow;
    for (int i = 0; i < 10; i++) rx_push(8'(8'h40 + i));
    for (int i = 0; i < 8; i++) rd_check("R7 kept byte", A_RXD, 32'(8'h40 + i));
    rd_check("R7 extras dropped", A_RXD, 32'h8000_0000);
  endtask

  task automatic t_tx;
    wr(A_TXD, 32'hFFFF_FF11);
    wr(A_TXD, 32'h22);
    wr(A_TXD, 32'h33);
    tx_take("R4 tx first", 8'h11);
    tx_take("R4 tx second", 8'h22);
    tx_take("R4 tx third", 8'h33);
    @(negedge clk);
    check("R4 tx empty", {31'b0, tx_valid}, 0);
  endtask

  task automatic t_tx_full;
    for (int i = 0; i < 9; i++) wr(A_TXD, 32'(8'h60 + i));
    rd_check("R6 full flag", A_TXD, 32'h8000_0000);
    tx_take("R5 first out", 8'h60);
    rd_check("R6 flag cleared", A_TXD, 0);
    for (int i = 1; i < 8; i++) tx_take("R5 order", 8'(8'h60 + i));
    @(negedge clk);
    check("R5 ninth discarded", {31'b0, tx_valid}, 0);
  endtask

  task automatic t_wm;
    wr(A_RXC, 32'h0002_0000);
    rx_push(8'h01); rx_push(8'h02);
    rd_check("R8 rx at mark", A_IPND, 0);
    rx_push(8'h03);
    rd_check("R8 rx over mark", A_IPND, 32'h2);
    wr(A_TXC, 32'h0001_0000);
    rd_check("R8 tx below mark", A_IPND, 32'h3);
    wr(A_TXD, 32'h77);
    rd_check("R8 tx at mark", A_IPND, 32'h2);
    tx_take("R8 drain", 8'h77);
    for (int i = 0; i < 3; i++) rd_check("R8 rx drain", A_RXD, 32'(i + 1));
    rd_check("R8 after drain", A_IPND, 32'h1);
    wr(A_TXC, 0);
    wr(A_RXC, 0);
  endtask

  task automatic t_irq;
    wr(A_IEN, 32'h2);
    check("R9 rx enable empty", {31'b0, irq}, 0);
    rx_push(8'h9A);
    check("R9 rx enable data", {31'b0, irq}, 1);
    rd_check("R9 pop byte", A_RXD, 32'h9A);
    check("R9 rx drained", {31'b0, irq}, 0);
    wr(A_IEN, 32'h1);
    check("R9 tx enable", {31'b0, irq}, 1);
    wr(A_IEN, 32'h0);
    check("R9 all off", {31'b0, irq}, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++; checks++;
    $display("FAIL watchdog: got 0x%08h expected 0x%08h", 32'd1, 32'd0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_regs();
    t_unmapped();
    t_access();
    t_rx();
    t_rx_overflow();
    t_tx();
    t_tx_full();
    t_wm();
    t_irq();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule